// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address from an operand specifier built from up to three parts: an optional base register, an optional index register multiplied by a power-of-two scale, and an optional signed displacement. The index multiplier is 1, 2, 4 or 8. The displacement is carried in one, two or four bytes. The register file holds eight 32-bit integer registers. The block drives two read selects towards it and takes the read data back in the same cycle. The sum wraps modulo 2^32.

A request is accepted when `req_valid` and `req_ready` are both high. The result is held in an output register behind `rsp_valid`/`rsp_ready`. A new request can be accepted in the same cycle that the held result is drained. The stack-pointer register (select value 4) may not be used as an index. When it is, the response carries `rsp_illegal`, the address output keeps its previous value, and `rsp_valid` is still raised.

Control is a two-state machine. `ST_EMPTY` means no result is held. `ST_FULL` means a result is held.
- `T_LOAD`: `ST_EMPTY` to `ST_FULL` when a request is accepted.
- `T_STALL`: `ST_FULL` to `ST_FULL` while `rsp_ready` is low.
- `T_RELOAD`: `ST_FULL` to `ST_FULL` when the result drains and a new request is accepted in the same cycle.
- `T_DRAIN`: `ST_FULL` to `ST_EMPTY` when the result drains and no request arrives.
- `T_IDLE`: `ST_EMPTY` to `ST_EMPTY` when there is no request.

Top module: `scaled_ea_gen`

## Requirements
- R1: For an accepted legal request, `rsp_addr` becomes base + (index << scale) + displacement modulo 2^32. It is presented with `rsp_valid` high from the cycle after the accepting edge.
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: `disp_size` selects the displacement:
  - 0: no displacement (zero).
  - 1: `disp_val[7:0]` sign-extended.
  - 2: `disp_val[15:0]` sign-extended.
  - 3: all 32 bits.
  Bits above the selected size are ignored.
- R4: When `base_use` is low, the base contributes zero. When `index_use` is low, the index contributes zero and the value of `index_sel` is ignored, including for the illegal check.
- R5: An accepted request with `index_use` high and `index_sel` equal to 4 gives `rsp_illegal` high with `rsp_valid` high, and `rsp_addr` keeps its previous value. Select 4 used as a base is legal. A legal request gives `rsp_illegal` low.
- R6: `req_ready` is high when no result is held or when `rsp_ready` is high. A request is taken only when `req_valid` and `req_ready` are both high. A drained result with no new request leaves `rsp_valid` low.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_addr` and `rsp_illegal` hold their values.
- R8: During and right after reset, `rsp_valid`, `rsp_illegal` and `rsp_addr` are zero.
- R9: `rf_sel_base` equals `base_sel` and `rf_sel_index` equals `index_sel` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| base_use | input | 1 | Base register present |
| base_sel | input | 3 | Base register number |
| index_use | input | 1 | Index register present |
| index_sel | input | 3 | Index register number |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp_size | input | 2 | Displacement size code |
| disp_val | input | 32 | Displacement field |
| rf_sel_base | output | 3 | Register file read select for the base |
| rf_data_base | input | 32 | Register file read data for the base |
| rf_sel_index | output | 3 | Register file read select for the index |
| rf_data_index | input | 32 | Register file read data for the index |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Effective address |
| rsp_illegal | output | 1 | Stack pointer was selected as index |

## Verification
Every result is due one clock edge after the edge that accepted its request. `req_ready` and the read selects follow their inputs within the same cycle. The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge, and the outputs are compared against it on the next falling edge, so each value is checked exactly in the cycle it is due, including cycles of backpressure. The directed cases wait one edge after acceptance and then compare against literal addresses.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned REG_NUM  = 8;
    localparam int unsigned SEL_W    = $clog2(REG_NUM);
    localparam int unsigned SCALE_W  = 2;
    localparam int unsigned SP_INDEX = 4;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_B8   = 2'd1,
        DISP_B16  = 2'd2,
        DISP_B32  = 2'd3
    } disp_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
    import eag_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [1:0]    size_code,
    input  logic [AW-1:0] raw,
    output logic [AW-1:0] ext
);
    localparam int unsigned PAD8  = AW - 8;
    localparam int unsigned PAD16 = AW - 16;

    always_comb begin
        unique case (disp_size_e'(size_code))
            DISP_NONE: ext = '0;
            DISP_B8:   ext = {{PAD8{raw[7]}}, raw[7:0]};
            DISP_B16:  ext = {{PAD16{raw[15]}}, raw[15:0]};
            default:   ext = raw;
        endcase
    end
endmodule

// File: rtl/eag_index_scale.sv
module eag_index_scale
    import eag_pkg::*;
#(
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned SW     = SEL_W,
    parameter int unsigned CW     = SCALE_W,
    parameter int unsigned SP_SEL = SP_INDEX
) (
    input  logic          use_idx,
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] data,
    input  logic [CW-1:0] scale,
    output logic [AW-1:0] term,
    output logic          bad_sel
);
    localparam int unsigned NSHIFT = 1 << CW;
    localparam logic [SW-1:0] SP_CODE = SW'(SP_SEL);

    logic [AW-1:0] shifted [NSHIFT];

    for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
        assign shifted[s] = data << s;
    end

    always_comb begin
        term    = use_idx ? shifted[scale] : '0;
        bad_sel = use_idx && (sel == SP_CODE);
    end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
    import eag_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          base_use,
    input  logic [AW-1:0] base_data,
    input  logic [AW-1:0] index_term,
    input  logic [AW-1:0] disp_term,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base_term;

    always_comb begin
        base_term = base_use ? base_data : '0;
        sum       = base_term + index_term + disp_term;
    end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          rsp_ready,
    input  logic [AW-1:0] addr_in,
    input  logic          illegal_in,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_illegal
);
    ctrl_state_e state_q, state_d;
    logic        take;

    always_comb begin
        req_ready = (state_q == ST_EMPTY) || rsp_ready;
        take      = req_valid && req_ready;
        unique case (state_q)
            ST_EMPTY: state_d = take ? ST_FULL : ST_EMPTY;
            ST_FULL: begin
                if (!rsp_ready)  state_d = ST_FULL;
                else if (take)   state_d = ST_FULL;
                else             state_d = ST_EMPTY;
            end
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr    <= '0;
            rsp_illegal <= 1'b0;
        end else if (take) begin
            rsp_illegal <= illegal_in;
            if (!illegal_in) rsp_addr <= addr_in;
        end
    end

    assign rsp_valid = (state_q == ST_FULL);
endmodule

// File: rtl/scaled_ea_gen.sv
module scaled_ea_gen
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        base_use,
    input  logic [2:0]  base_sel,
    input  logic        index_use,
    input  logic [2:0]  index_sel,
    input  logic [1:0]  scale_code,
    input  logic [1:0]  disp_size,
    input  logic [31:0] disp_val,
    output logic [2:0]  rf_sel_base,
    input  logic [31:0] rf_data_base,
    output logic [2:0]  rf_sel_index,
    input  logic [31:0] rf_data_index,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_addr,
    output logic        rsp_illegal
);
    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] ea_sum;
    logic              index_bad;

    assign rf_sel_base  = base_sel;
    assign rf_sel_index = index_sel;

    eag_disp_ext #(.AW(ADDR_W)) u_disp (
        .size_code (disp_size),
        .raw       (disp_val),
        .ext       (disp_term)
    );

    eag_index_scale #(
        .AW(ADDR_W), .SW(SEL_W), .CW(SCALE_W), .SP_SEL(SP_INDEX)
    ) u_index (
        .use_idx (index_use),
        .sel     (index_sel),
        .data    (rf_data_index),
        .scale   (scale_code),
        .term    (index_term),
        .bad_sel (index_bad)
    );

    eag_sum #(.AW(ADDR_W)) u_sum (
        .base_use   (base_use),
        .base_data  (rf_data_base),
        .index_term (index_term),
        .disp_term  (disp_term),
        .sum        (ea_sum)
    );

    eag_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .rsp_ready   (rsp_ready),
        .addr_in     (ea_sum),
        .illegal_in  (index_bad),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_addr    (rsp_addr),
        .rsp_illegal (rsp_illegal)
    );
endmodule

// File: rtl/scaled_ea_gen_chk.sv
module scaled_ea_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        base_use,
    input logic        index_use,
    input logic [2:0]  index_sel,
    input logic [1:0]  disp_size,
    input logic [31:0] rf_data_base,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_addr,
    input logic        rsp_illegal
);
    logic take;
    logic sp_index;
    assign take     = req_valid && req_ready;
    assign sp_index = index_use && (index_sel == 3'd4);

    a_r1_base_only: assert property (@(posedge clk) disable iff (!rst_n)
        take && base_use && !index_use && disp_size == 2'd0
        |=> rsp_valid && rsp_addr == $past(rf_data_base));

    a_r4_nothing_present: assert property (@(posedge clk) disable iff (!rst_n)
        take && !base_use && !index_use && disp_size == 2'd0
        |=> rsp_addr == 32'd0 && !rsp_illegal);

    a_r5_sp_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        take && sp_index |=> rsp_valid && rsp_illegal && $stable(rsp_addr));

    a_r5_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        take && !sp_index |=> !rsp_illegal);

    a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rsp_valid);

    a_r6_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready
        |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_illegal));
endmodule

bind scaled_ea_gen scaled_ea_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .base_use     (base_use),
    .index_use    (index_use),
    .index_sel    (index_sel),
    .disp_size    (disp_size),
    .rf_data_base (rf_data_base),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_addr     (rsp_addr),
    .rsp_illegal  (rsp_illegal)
);

// File: tb/scaled_ea_gen_test.sv
module scaled_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        base_use = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        index_use = 1'b0;
    logic [2:0]  index_sel = '0;
    logic [1:0]  scale_code = '0;
    logic [1:0]  disp_size = '0;
    logic [31:0] disp_val = '0;
    logic [2:0]  rf_sel_base, rf_sel_index;
    logic [31:0] rf_data_base, rf_data_index;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic        rsp_illegal;

    logic [31:0] rf [8];
    int total = 0;
    int bad = 0;
    string phase = "R8";

    logic        m_valid = 1'b0;
    logic [31:0] m_addr = '0;
    logic        m_ill = 1'b0;

    always #10 clk = ~clk;

    assign rf_data_base  = rf[rf_sel_base];
    assign rf_data_index = rf[rf_sel_index];

    scaled_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .base_use(base_use), .base_sel(base_sel), .index_use(index_use),
        .index_sel(index_sel), .scale_code(scale_code), .disp_size(disp_size),
        .disp_val(disp_val), .rf_sel_base(rf_sel_base), .rf_data_base(rf_data_base),
        .rf_sel_index(rf_sel_index), .rf_data_index(rf_data_index),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_illegal(rsp_illegal)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_ea(logic bu, logic [31:0] bd, logic iu,
                                           logic [31:0] id, logic [1:0] sc,
                                           logic [1:0] ds, logic [31:0] dv);
        int d;
        int s;
        case (ds)
            2'd0: d = 0;
            2'd1: d = int'($signed(dv[7:0]));
            2'd2: d = int'($signed(dv[15:0]));
            default: d = int'(dv);
        endcase
        s = d;
        if (bu) s = s + int'(bd);
        if (iu) s = s + int'(id) * (1 << sc);
        return 32'(s);
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_addr  <= '0;
            m_ill   <= 1'b0;
        end else if (req_valid && (!m_valid || rsp_ready)) begin
            m_valid <= 1'b1;
            if (index_use && index_sel == 3'd4) begin
                m_ill <= 1'b1;
            end else begin
                m_ill  <= 1'b0;
                m_addr <= ref_ea(base_use, rf[base_sel], index_use, rf[index_sel],
                                 scale_code, disp_size, disp_val);
            end
        end else if (rsp_ready) begin
            m_valid <= 1'b0;
        end
    end

    // comparison every cycle, on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R8 valid in reset", {31'd0, rsp_valid}, 32'd0);
            check("R8 addr in reset", rsp_addr, 32'd0);
            check("R8 illegal in reset", {31'd0, rsp_illegal}, 32'd0);
        end else begin
            check("R9 base select", {29'd0, rf_sel_base}, {29'd0, base_sel});
            check("R9 index select", {29'd0, rf_sel_index}, {29'd0, index_sel});
            check({phase, " R6 ready"}, {31'd0, req_ready}, {31'd0, !m_valid || rsp_ready});
            check({phase, " R6/R7 valid"}, {31'd0, rsp_valid}, {31'd0, m_valid});
            if (m_valid) begin
                check({phase, " R1 address"}, rsp_addr, m_addr);
                check({phase, " R5 illegal"}, {31'd0, rsp_illegal}, {31'd0, m_ill});
            end
        end
    end

    task automatic issue(logic bu, logic [2:0] bs, logic iu, logic [2:0] is,
                         logic [1:0] sc, logic [1:0] ds, logic [31:0] dv);
        @(negedge clk);
        req_valid = 1'b1; base_use = bu; base_sel = bs; index_use = iu;
        index_sel = is; scale_code = sc; disp_size = ds; disp_val = dv;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(string req, logic [31:0] addr, logic ill);
        check({req, " direct address"}, rsp_addr, addr);
        check({req, " direct illegal"}, {31'd0, rsp_illegal}, {31'd0, ill});
        check({req, " direct valid"}, {31'd0, rsp_valid}, 32'd1);
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 * i + 32'h11;
        rf[1] = 32'h0000_0100;
        rf[2] = 32'h0000_F000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // worked cases (R1)
        phase = "R1";
        issue(1, 2, 0, 0, 0, 1, 32'h8);   expect_rsp("R1 base+disp8", 32'h0000_F008, 0);
        issue(1, 2, 1, 1, 0, 0, 32'h0);   expect_rsp("R1 base+index", 32'h0000_F100, 0);
        issue(1, 2, 1, 1, 2, 0, 32'h0);   expect_rsp("R1 base+index*4", 32'h0000_F400, 0);
        issue(0, 0, 1, 2, 1, 2, 32'h80);  expect_rsp("R1 index*2+disp16", 32'h0001_E080, 0);
        rf[6] = 32'hFFFF_FFF0;
        issue(1, 6, 0, 0, 0, 1, 32'h20);  expect_rsp("R1 wrap", 32'h0000_0010, 0);

        // scales (R2)
        phase = "R2";
        for (int s = 0; s < 4; s++) begin
            issue(0, 0, 1, 1, 2'(s), 0, 32'h0);
            expect_rsp("R2 scale", 32'h100 << s, 0);
        end

        // displacement sizes (R3)
        phase = "R3";
        issue(0, 0, 0, 0, 0, 1, 32'h1234_5680); expect_rsp("R3 byte neg", 32'hFFFF_FF80, 0);
        issue(0, 2, 1, 2, 1, 1, 32'h80);        expect_rsp("R3 byte sext", 32'h0001_DF80, 0);
        issue(0, 0, 0, 0, 0, 2, 32'h1234_8001); expect_rsp("R3 half neg", 32'hFFFF_8001, 0);
        issue(0, 0, 0, 0, 0, 2, 32'hABCD_7FFF); expect_rsp("R3 half pos", 32'h0000_7FFF, 0);
        issue(0, 0, 0, 0, 0, 3, 32'h1234_8001); expect_rsp("R3 word", 32'h1234_8001, 0);
        issue(0, 0, 0, 0, 0, 0, 32'hDEAD_BEEF); expect_rsp("R3 none", 32'h0000_0000, 0);

        // absent parts (R4)
        phase = "R4";
        issue(0, 7, 0, 4, 3, 1, 32'h10); expect_rsp("R4 absent base and sp index", 32'h10, 0);
        issue(1, 3, 0, 5, 3, 0, 32'h0);  expect_rsp("R4 absent index", rf[3], 0);

        // stack pointer as index (R5)
        phase = "R5";
        issue(1, 2, 0, 0, 0, 1, 32'h4);  expect_rsp("R5 setup", 32'h0000_F004, 0);
        issue(1, 2, 1, 4, 0, 0, 32'h0);  expect_rsp("R5 sp index", 32'h0000_F004, 1);
        issue(0, 0, 1, 4, 3, 3, 32'h55); expect_rsp("R5 sp index again", 32'h0000_F004, 1);
        issue(1, 4, 1, 1, 0, 0, 32'h0);  expect_rsp("R5 sp base legal", rf[4] + 32'h100, 0);

        // random traffic with backpressure (R6, R7)
        phase = "R6/R7";
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c % 97 == 0) rf[$urandom_range(0, 7)] = $urandom;
            req_valid  = ($urandom_range(0, 3) != 0);
            rsp_ready  = ($urandom_range(0, 2) != 0);
            base_use   = 1'($urandom);
            base_sel   = 3'($urandom);
            index_use  = 1'($urandom);
            index_sel  = 3'($urandom);
            scale_code = 2'($urandom);
            disp_size  = 2'($urandom);
            disp_val   = $urandom;
        end
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 drained", {31'd0, rsp_valid}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule